// File: doc/BRIEF.md
# Extended CRTC Control Register Bank

This block is a small bank of extension registers that sits behind a display controller's CRTC index/data port pair and answers to indices 2Ah through 3Fh. A separate unlock register elsewhere in the controller supplies a single unlock flag. While that flag is low, the bank hides its contents and refuses writes. While it is high, software can read and write five registers: a display-switch register, a scratch byte, a pair of interlace half-line position registers with an enable bit, and a miscellaneous control byte.

The display-switch register is not a plain latch. On readback, its upper nibble is ORed with four live strap pins, so software sees both the board configuration and whatever it wrote. The interlace end register keeps only the interlace enable bit and a 5-bit end position. The stored interlace enable, start and end values, and the other register contents, are driven out as registered ports for the timing logic that follows. This block does not produce interlaced timing itself.

The bus side is one index, one write strobe with write data, and a combinational read-data output for the index currently presented. A write takes effect on the rising clock edge where the strobe is high.

Top module: `xcrt_bank`

## Requirements
- R1: While `unlock` is low, any index from 2Ah to 3Fh reads FFh.
- R2: With the bank unlocked, index 2Ah reads `{strap_in, 4'b0000}` ORed with the stored switch byte, and a write to 2Ah stores all eight data bits.
- R3: With the bank unlocked, index 2Bh is an 8-bit scratch byte that reads back the last value written and appears on `scratch_q`.
- R4: With the bank unlocked, index 2Ch stores an 8-bit interlace start value that reads back and appears on `ilace_start`.
- R5: With the bank unlocked, a write to 2Dh stores data bit 5 as `ilace_en` and bits 4:0 as `ilace_end`, and drops bits 7:6. Reading 2Dh returns the enable in bit 5 and the end value in bits 4:0, with bits 7:6 at zero.
- R6: With the bank unlocked, index 2Eh is an 8-bit control byte that reads back and appears on `misc_q`.
- R7: Synchronous reset sets the switch byte to F0h and clears the scratch byte, the start value, the end value, the enable bit and the control byte.
- R8: A write while `unlock` is low changes no register.
- R9: With the bank unlocked, indices 2Fh to 3Fh read 00h, and writes to them change no register.
- R10: Indices outside 2Ah–3Fh read 00h and writes to them change no register, whatever the state of `unlock`.
- R11: All register outputs change only at the clock edge that samples the write, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| unlock | input | 1 | Bank unlocked when high |
| idx | input | 8 | Register index |
| wr_en | input | 1 | Write strobe for the current index |
| wr_data | input | 8 | Write data |
| strap_in | input | 4 | Live board strap pins |
| rd_data | output | 8 | Read data for the current index |
| sw_q | output | 8 | Stored switch byte |
| scratch_q | output | 8 | Scratch byte |
| misc_q | output | 8 | Miscellaneous control byte |
| ilace_en | output | 1 | Interlace enable |
| ilace_start | output | 8 | Interlace half-line start |
| ilace_end | output | 5 | Interlace half-line end |

## Verification
The bench targets the switch register's read merge with several strap patterns. A design that replaces the stored nibble instead of ORing with it loses written high bits. A design that ignores the pins returns the wrong board configuration. Writes of FFh and C0h to 2Dh check that bits 7:6 are dropped while bit 5 and bits 4:0 keep their places, since a design that kept the whole byte would read back FFh. Writes made while locked, and writes to spare or out-of-range indices, are each followed by a readback of every register, which exposes a decoder that aliases those indices onto real registers. The bench also samples the outputs between the write strobe and the clock edge, which catches a design that passes write data straight through to its outputs.

// File: rtl/xcrt_pkg.sv
package xcrt_pkg;
    localparam int DW      = 8;
    localparam int STRAP_W = 4;
    localparam int END_W   = 5;
    localparam int EN_BIT  = 5;

    localparam logic [DW-1:0] IDX_SWITCH  = 8'h2A;
    localparam logic [DW-1:0] IDX_SCRATCH = 8'h2B;
    localparam logic [DW-1:0] IDX_HSTART  = 8'h2C;
    localparam logic [DW-1:0] IDX_HEND    = 8'h2D;
    localparam logic [DW-1:0] IDX_MISC    = 8'h2E;
    localparam logic [DW-1:0] IDX_FIRST   = 8'h2A;
    localparam logic [DW-1:0] IDX_LAST    = 8'h3F;

    localparam logic [DW-1:0] SWITCH_RST  = 8'hF0;
    localparam logic [DW-1:0] LOCKED_VAL  = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_SCRATCH,
        SEL_HSTART,
        SEL_HEND,
        SEL_MISC,
        SEL_SPARE
    } sel_e;

    typedef struct packed {
        logic [DW-1:0]    sw;
        logic [DW-1:0]    scratch;
        logic [DW-1:0]    hstart;
        logic             hen;
        logic [END_W-1:0] hend;
        logic [DW-1:0]    misc;
    } bank_t;

    function automatic sel_e decode_idx(input logic [DW-1:0] idx);
        sel_e s;
        if (idx < IDX_FIRST || idx > IDX_LAST) s = SEL_NONE;
        else begin
            case (idx)
                IDX_SWITCH:  s = SEL_SWITCH;
                IDX_SCRATCH: s = SEL_SCRATCH;
                IDX_HSTART:  s = SEL_HSTART;
                IDX_HEND:    s = SEL_HEND;
                IDX_MISC:    s = SEL_MISC;
                default:     s = SEL_SPARE;
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/xcrt_decode.sv
module xcrt_decode
    import xcrt_pkg::*;
(
    input  logic [DW-1:0] idx,
    output sel_e          sel
);
    always_comb sel = decode_idx(idx);
endmodule

// File: rtl/xcrt_regs.sv
module xcrt_regs
    import xcrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          unlock,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output bank_t         q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.sw      <= SWITCH_RST;
            q.scratch <= '0;
            q.hstart  <= '0;
            q.hen     <= 1'b0;
            q.hend    <= '0;
            q.misc    <= '0;
        end else if (wr_en && unlock) begin
            case (sel)
                SEL_SWITCH:  q.sw      <= wdata;
                SEL_SCRATCH: q.scratch <= wdata;
                SEL_HSTART:  q.hstart  <= wdata;
                SEL_HEND: begin
                    q.hen  <= wdata[EN_BIT];
                    q.hend <= wdata[END_W-1:0];
                end
                SEL_MISC:    q.misc    <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xcrt_rdmux.sv
module xcrt_rdmux
    import xcrt_pkg::*;
(
    input  sel_e               sel,
    input  logic               unlock,
    input  logic [STRAP_W-1:0] strap,
    input  bank_t              q,
    output logic [DW-1:0]      rdata
);
    localparam int HEND_PAD = DW - EN_BIT - 1;
    localparam int GAP_W    = EN_BIT - END_W;

    logic [DW-1:0] hend_word;
    logic [DW-1:0] strap_word;

    always_comb begin
        hend_word = {{HEND_PAD{1'b0}}, q.hen, {GAP_W{1'b0}}, q.hend};
        strap_word = {strap, {(DW-STRAP_W){1'b0}}};
        if (sel == SEL_NONE)   rdata = '0;
        else if (!unlock)      rdata = LOCKED_VAL;
        else begin
            case (sel)
                SEL_SWITCH:  rdata = strap_word | q.sw;
                SEL_SCRATCH: rdata = q.scratch;
                SEL_HSTART:  rdata = q.hstart;
                SEL_HEND:    rdata = hend_word;
                SEL_MISC:    rdata = q.misc;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xcrt_bank.sv
module xcrt_bank
    import xcrt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               unlock,
    input  logic [DW-1:0]      idx,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [DW-1:0]      rd_data,
    output logic [DW-1:0]      sw_q,
    output logic [DW-1:0]      scratch_q,
    output logic [DW-1:0]      misc_q,
    output logic               ilace_en,
    output logic [DW-1:0]      ilace_start,
    output logic [END_W-1:0]   ilace_end
);
    sel_e  sel;
    bank_t q;

    xcrt_decode u_dec (.idx(idx), .sel(sel));

    xcrt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock),
        .sel(sel), .wdata(wr_data), .q(q)
    );

    xcrt_rdmux u_rd (
        .sel(sel), .unlock(unlock), .strap(strap_in), .q(q), .rdata(rd_data)
    );

    assign sw_q        = q.sw;
    assign scratch_q   = q.scratch;
    assign misc_q      = q.misc;
    assign ilace_en    = q.hen;
    assign ilace_start = q.hstart;
    assign ilace_end   = q.hend;
endmodule

// File: rtl/xcrt_bank_chk.sv
module xcrt_bank_chk
    import xcrt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               unlock,
    input logic [DW-1:0]      idx,
    input logic               wr_en,
    input logic [DW-1:0]      wr_data,
    input logic [STRAP_W-1:0] strap_in,
    input logic [DW-1:0]      rd_data,
    input logic [DW-1:0]      sw_q,
    input logic [DW-1:0]      scratch_q,
    input logic [DW-1:0]      misc_q,
    input logic               ilace_en,
    input logic [DW-1:0]      ilace_start,
    input logic [END_W-1:0]   ilace_end
);
    logic in_bank;
    assign in_bank = (idx >= IDX_FIRST) && (idx <= IDX_LAST);

    a_r1_locked_ff: assert property (@(posedge clk) disable iff (rst)
        (!unlock && in_bank) |-> rd_data == LOCKED_VAL);

    a_r2_strap_visible: assert property (@(posedge clk) disable iff (rst)
        (unlock && idx == IDX_SWITCH) |-> ((rd_data[DW-1:DW-STRAP_W] & strap_in) == strap_in));

    a_r5_hend_top_zero: assert property (@(posedge clk) disable iff (rst)
        (unlock && idx == IDX_HEND) |-> rd_data[DW-1:EN_BIT+1] == '0);

    a_r5_hend_write: assert property (@(posedge clk) disable iff (rst)
        (unlock && wr_en && idx == IDX_HEND) |=>
            (ilace_en == $past(wr_data[EN_BIT]) && ilace_end == $past(wr_data[END_W-1:0])));

    a_r7_reset_vals: assert property (@(posedge clk)
        rst |=> (sw_q == SWITCH_RST && scratch_q == '0 && misc_q == '0 &&
                 !ilace_en && ilace_start == '0 && ilace_end == '0));

    a_r8_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (!unlock) |=> ($stable(sw_q) && $stable(scratch_q) && $stable(misc_q) &&
                       $stable(ilace_en) && $stable(ilace_start) && $stable(ilace_end)));

    a_r10_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (!in_bank) |-> rd_data == '0);
endmodule

bind xcrt_bank xcrt_bank_chk chk (.*);

// File: tb/xcrt_bank_test.sv
module xcrt_bank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       unlock = 1'b0;
    logic [7:0] idx = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] strap_in = 4'h0;
    logic [7:0] rd_data, sw_q, scratch_q, misc_q, ilace_start;
    logic       ilace_en;
    logic [4:0] ilace_end;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xcrt_bank uut (
        .clk(clk), .rst(rst), .unlock(unlock), .idx(idx), .wr_en(wr_en),
        .wr_data(wr_data), .strap_in(strap_in), .rd_data(rd_data),
        .sw_q(sw_q), .scratch_q(scratch_q), .misc_q(misc_q),
        .ilace_en(ilace_en), .ilace_start(ilace_start), .ilace_end(ilace_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        idx = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        idx = a;
        #1 d = rd_data;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic expect_all(input string req, input logic [7:0] s, input logic [7:0] sc,
                              input logic [7:0] hs, input logic [7:0] he, input logic [7:0] m);
        expect_rd(req, 8'h2A, s | {strap_in, 4'h0});
        expect_rd(req, 8'h2B, sc);
        expect_rd(req, 8'h2C, hs);
        expect_rd(req, 8'h2D, he);
        expect_rd(req, 8'h2E, m);
    endtask

    task automatic t_reset;
        unlock = 1'b1; strap_in = 4'h0;
        expect_all("R7", 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00);
        check("R7 ilace_en", {31'h0, ilace_en}, 32'h0);
        check("R7 sw_q", {24'h0, sw_q}, 32'hF0);
        strap_in = 4'h3;
        expect_rd("R2 reset+strap", 8'h2A, 8'hF0);
        strap_in = 4'h0;
    endtask

    task automatic t_locked_read;
        unlock = 1'b0;
        expect_rd("R1 2A", 8'h2A, 8'hFF);
        expect_rd("R1 2D", 8'h2D, 8'hFF);
        expect_rd("R1 3F", 8'h3F, 8'hFF);
        unlock = 1'b1;
    endtask

    task automatic t_switch;
        strap_in = 4'h0;
        wr(8'h2A, 8'h05);
        expect_rd("R2 stored", 8'h2A, 8'h05);
        check("R2 sw_q", {24'h0, sw_q}, 32'h05);
        strap_in = 4'hA;
        expect_rd("R2 strap OR", 8'h2A, 8'hA5);
        wr(8'h2A, 8'h43);
        expect_rd("R2 OR keeps stored bit", 8'h2A, 8'hE3);
        strap_in = 4'h0;
        expect_rd("R2 strap low", 8'h2A, 8'h43);
    endtask

    task automatic t_simple;
        wr(8'h2B, 8'h5A);
        expect_rd("R3", 8'h2B, 8'h5A);
        check("R3 scratch_q", {24'h0, scratch_q}, 32'h5A);
        wr(8'h2C, 8'hC3);
        expect_rd("R4", 8'h2C, 8'hC3);
        check("R4 ilace_start", {24'h0, ilace_start}, 32'hC3);
        wr(8'h2E, 8'h81);
        expect_rd("R6", 8'h2E, 8'h81);
        check("R6 misc_q", {24'h0, misc_q}, 32'h81);
    endtask

    task automatic t_hend;
        wr(8'h2D, 8'hFF);
        expect_rd("R5 FF", 8'h2D, 8'h3F);
        check("R5 en", {31'h0, ilace_en}, 32'h1);
        check("R5 end", {27'h0, ilace_end}, 32'h1F);
        wr(8'h2D, 8'hC0);
        expect_rd("R5 C0", 8'h2D, 8'h00);
        check("R5 en off", {31'h0, ilace_en}, 32'h0);
        wr(8'h2D, 8'h25);
        expect_rd("R5 25", 8'h2D, 8'h25);
        check("R5 end 05", {27'h0, ilace_end}, 32'h05);
    endtask

    task automatic t_locked_write;
        unlock = 1'b0;
        wr(8'h2A, 8'h00); wr(8'h2B, 8'h00); wr(8'h2C, 8'h11);
        wr(8'h2D, 8'h00); wr(8'h2E, 8'h00);
        check("R8 ilace_en", {31'h0, ilace_en}, 32'h1);
        unlock = 1'b1;
        expect_all("R8", 8'h43, 8'h5A, 8'hC3, 8'h25, 8'h81);
    endtask

    task automatic t_spare;
        wr(8'h2F, 8'hAA);
        wr(8'h30, 8'hAA);
        wr(8'h3F, 8'hAA);
        expect_rd("R9 2F", 8'h2F, 8'h00);
        expect_rd("R9 30", 8'h30, 8'h00);
        expect_rd("R9 3F", 8'h3F, 8'h00);
        expect_all("R9 no alias", 8'h43, 8'h5A, 8'hC3, 8'h25, 8'h81);
    endtask

    task automatic t_outside;
        wr(8'h0A, 8'h00); wr(8'h0B, 8'h00); wr(8'h29, 8'h00); wr(8'h40, 8'h00);
        expect_rd("R10 29 unlocked", 8'h29, 8'h00);
        expect_rd("R10 40 unlocked", 8'h40, 8'h00);
        unlock = 1'b0;
        expect_rd("R10 29 locked", 8'h29, 8'h00);
        expect_rd("R10 0A locked", 8'h0A, 8'h00);
        unlock = 1'b1;
        expect_all("R10 no alias", 8'h43, 8'h5A, 8'hC3, 8'h25, 8'h81);
    endtask

    task automatic t_timing;
        @(negedge clk);
        idx = 8'h2C; wr_data = 8'h9E; wr_en = 1'b1;
        #5;
        check("R11 before edge", {24'h0, ilace_start}, 32'hC3);
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 after edge", {24'h0, ilace_start}, 32'h9E);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_locked_read;
        t_switch;
        t_simple;
        t_hend;
        t_locked_write;
        t_spare;
        t_outside;
        t_timing;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule